// File: doc/BRIEF.md
# Handshake pipeline with external stage enables

This block is a chain of datapath registers that can be advanced in two ways. In handshake mode each stage moves data with a local valid/ready rule, so the block behaves like an ordinary elastic pipeline. In external mode a surrounding controller drives one enable bit per stage. This lets the stages of this unit step in lock-step with other units that share one in-order main pipeline, and the control logic can run ahead of the data. Each stage's load enable is the OR of its handshake enable and its external bit. When the external vector is held at zero, the block is exactly the handshake pipeline. When the input valid is held low, only the external bits move data.

The data word is split into lanes, and each lane carries an enable bit along with it. Every stage adds one to each lane, a stand-in for real arithmetic. In the default output mode, a lane is replaced by all ones when the output is not valid or when that lane's enable is low. A mode parameter turns this masking off. That parameter must be set when external enables are used, because the valid bits then stay low. The enable port width is a separate parameter, so that a zero-stage build, which is purely combinational, still has a legal port.

Top module: `pipe_ena_top`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted and just after it, out_valid is 0 and in_ready is 1. In masking mode out_data is then all ones; in unmasked mode it is all zeros.
- R2: In handshake mode (ext_ena all zero), every word accepted on in_valid&&in_ready appears exactly once, in order, on out_valid&&out_ready. Each LANE_W-bit lane (lane l is bits [l*LANE_W +: LANE_W]) has been incremented by NUM_STAGES modulo 2^LANE_W. While out_valid is high and out_ready is low, the output holds.
- R3: With an empty pipeline and out_ready high, a word accepted at clock edge k shows on the output after edge k+NUM_STAGES-1 and not before.
- R4: A stage accepts when it is empty or when its content leaves in the same cycle. With out_ready low and in_valid high from empty, exactly NUM_STAGES words are accepted, and then in_ready is 0.
- R5: With OUT_RAW=0, each output lane is 8'hFF (all ones) when out_valid is 0 or when its lane enable (in_lanes[l], carried with the word) is 0.
- R6: A high ext_ena[s] loads stage s from its upstream (stage 0 from in_data), with each lane plus one, whatever valid and ready are. The loaded valid is the upstream valid.
- R7: A stage whose external bit and local enable are both low keeps its data.
- R8: With OUT_RAW=1, out_data is the last stage's data unmasked, even while out_valid is 0.
- R9: With NUM_STAGES=0 the block is combinational: out_valid=in_valid, in_ready=out_ready, and out_data is in_data with the R5 masking applied. ext_ena has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream may transfer |
| in_data | input | NUM_LANES*LANE_W | Upstream word |
| in_lanes | input | NUM_LANES | Per-lane enable carried with the word |
| ext_ena | input | EXT_ENA_W | External load enable, bit s for stage s |
| out_valid | output | 1 | Downstream word valid |
| out_ready | input | 1 | Downstream accepts |
| out_data | output | NUM_LANES*LANE_W | Downstream word, masked per OUT_RAW |

## Verification
Random stalls on both sides look for words that are lost, duplicated or reordered. A ready chain that ignores a draining downstream stage would cut throughput, and one that ignores a full stage would overwrite data. A fill test with the output blocked checks that exactly the stage count is accepted. A single-word test checks that the ORed enable adds no bubble cycle. A scripted pattern of external enables with the input valid low shows each stage moving only on its own bit. An enable decoded to the wrong stage, or a hold that leaks, shows up as a wrong lane sum at the output. A zero-stage build checks the combinational path and that the enable port has no effect.

// File: rtl/pipe_ena_pkg.sv
package pipe_ena_pkg;

  // Output lane handling.
  typedef enum logic {
    OUT_BOXED = 1'b0,
    OUT_PLAIN = 1'b1
  } out_mode_e;

  // Width of the external enable port; stays at least one bit.
  function automatic int unsigned ext_width(input int unsigned stages);
    return (stages > 0) ? stages : 1;
  endfunction

endpackage

// File: rtl/pe_stage.sv
module pe_stage #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    up_valid,
  input  logic [LANES*LANE_W-1:0] up_data,
  input  logic [LANES-1:0]        up_lanes,
  output logic                    up_ready,
  input  logic                    ext_ena,
  input  logic                    down_ready,
  output logic                    q_valid,
  output logic [LANES*LANE_W-1:0] q_data,
  output logic [LANES-1:0]        q_lanes
);

  localparam int unsigned DW = LANES * LANE_W;

  // Stand-in arithmetic: every lane incremented by one.
  function automatic logic [DW-1:0] step_lanes(input logic [DW-1:0] w);
    logic [DW-1:0] r;
    for (int l = 0; l < int'(LANES); l++) begin
      r[l*LANE_W +: LANE_W] = w[l*LANE_W +: LANE_W] + LANE_W'(1);
    end
    return r;
  endfunction

  logic          v_q;
  logic [DW-1:0] d_q;
  logic [LANES-1:0] l_q;

  // Named internal events.
  logic stage_open;   // empty, or draining this cycle
  logic hs_load;      // handshake-derived enable
  logic any_load;     // combined enable
  logic vacate;       // content leaves, nothing replaces it

  assign stage_open = !v_q || down_ready;
  assign hs_load    = up_valid && stage_open;
  assign any_load   = hs_load || ext_ena;
  assign vacate     = stage_open && !any_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
      l_q <= '0;
    end else if (any_load) begin
      v_q <= up_valid;
      d_q <= step_lanes(up_data);
      l_q <= up_lanes;
    end else if (vacate) begin
      v_q <= 1'b0;
    end
  end

  assign up_ready = stage_open;
  assign q_valid  = v_q;
  assign q_data   = d_q;
  assign q_lanes  = l_q;

  // A stalled stage with no external pulse keeps its content.
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !down_ready && !ext_ena) |=> (v_q && $stable(d_q)));

  // An external pulse with no upstream valid loads the incremented word, marked empty.
  assert_ext_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ena && !up_valid) |=> (!v_q && d_q == step_lanes($past(up_data))));

  // An offered word to an open stage is taken.
  assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> v_q);

endmodule

// File: rtl/pe_lane_mask.sv
module pe_lane_mask #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter bit          RAW    = 1'b0
) (
  input  logic                    valid,
  input  logic [LANES*LANE_W-1:0] data,
  input  logic [LANES-1:0]        lanes,
  output logic [LANES*LANE_W-1:0] masked
);

  function automatic logic [LANE_W-1:0] box_lane(input logic keep,
                                                 input logic [LANE_W-1:0] v);
    return keep ? v : {LANE_W{1'b1}};
  endfunction

  if (RAW) begin : g_plain
    logic unused_lanes;
    assign unused_lanes = valid ^ (^lanes);
    assign masked = data;
  end else begin : g_boxed
    for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
      assign masked[l*LANE_W +: LANE_W] =
        box_lane(valid && lanes[l], data[l*LANE_W +: LANE_W]);
    end
  end

endmodule

// File: rtl/pipe_ena_top.sv
module pipe_ena_top import pipe_ena_pkg::*; #(
  parameter int unsigned NUM_STAGES = 3,
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned LANE_W     = 8,
  parameter bit          OUT_RAW    = 1'b0,
  parameter int unsigned EXT_ENA_W  = ext_width(NUM_STAGES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [NUM_LANES*LANE_W-1:0] in_data,
  input  logic [NUM_LANES-1:0]        in_lanes,
  input  logic [EXT_ENA_W-1:0]        ext_ena,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [NUM_LANES*LANE_W-1:0] out_data
);

  localparam int unsigned DW = NUM_LANES * LANE_W;
  localparam out_mode_e   MODE = OUT_RAW ? OUT_PLAIN : OUT_BOXED;

  logic          tail_valid;
  logic [DW-1:0] tail_data;
  logic [NUM_LANES-1:0] tail_lanes;
  logic          ext_any;

  assign ext_any = |ext_ena;

  if (NUM_STAGES == 0) begin : g_comb
    logic unused_ext;
    assign unused_ext = ext_any;
    assign tail_valid = in_valid;
    assign tail_data  = in_data;
    assign tail_lanes = in_lanes;
    assign in_ready   = out_ready;
  end else begin : g_pipe
    logic          ch_valid [NUM_STAGES+1];
    logic          ch_ready [NUM_STAGES+1];
    logic [DW-1:0] ch_data  [NUM_STAGES+1];
    logic [NUM_LANES-1:0] ch_lanes [NUM_STAGES+1];

    assign ch_valid[0] = in_valid;
    assign ch_data[0]  = in_data;
    assign ch_lanes[0] = in_lanes;
    assign ch_ready[NUM_STAGES] = out_ready;
    assign in_ready = ch_ready[0];

    for (genvar s = 0; s < int'(NUM_STAGES); s++) begin : g_stage
      pe_stage #(.LANES(NUM_LANES), .LANE_W(LANE_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_valid  (ch_valid[s]),
        .up_data   (ch_data[s]),
        .up_lanes  (ch_lanes[s]),
        .up_ready  (ch_ready[s]),
        .ext_ena   (ext_ena[s]),
        .down_ready(ch_ready[s+1]),
        .q_valid   (ch_valid[s+1]),
        .q_data    (ch_data[s+1]),
        .q_lanes   (ch_lanes[s+1])
      );
    end

    assign tail_valid = ch_valid[NUM_STAGES];
    assign tail_data  = ch_data[NUM_STAGES];
    assign tail_lanes = ch_lanes[NUM_STAGES];

    // Output word held while stalled in handshake operation.
    assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !ext_any) |=> (out_valid && $stable(out_data)));
  end

  pe_lane_mask #(.LANES(NUM_LANES), .LANE_W(LANE_W), .RAW(MODE == OUT_PLAIN)) u_mask (
    .valid (tail_valid),
    .data  (tail_data),
    .lanes (tail_lanes),
    .masked(out_data)
  );

  assign out_valid = tail_valid;

  if (MODE == OUT_BOXED) begin : g_box_chk
    // Idle output is fully boxed.
    assert_box_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_data == {DW{1'b1}}));
  end

endmodule

// File: tb/pipe_ena_top_tb.sv
`timescale 1ns/1ps
module pipe_ena_top_tb;

  localparam int N  = 3;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Handshake instance
  logic h_in_valid = 0, h_in_ready, h_out_valid, h_out_ready = 0;
  logic [DW-1:0] h_in_data = '0, h_out_data;
  logic [3:0] h_lanes = '0;
  logic [N-1:0] h_ena = '0;

  pipe_ena_top #(.NUM_STAGES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(h_in_valid), .in_ready(h_in_ready),
    .in_data(h_in_data), .in_lanes(h_lanes), .ext_ena(h_ena),
    .out_valid(h_out_valid), .out_ready(h_out_ready), .out_data(h_out_data));

  // External-enable instance
  logic e_in_ready, e_out_valid;
  logic [DW-1:0] e_in_data = '0, e_out_data;
  logic [N-1:0] e_ena = '0;

  pipe_ena_top #(.NUM_STAGES(N), .OUT_RAW(1'b1)) u_dut_ext (
    .clk(clk), .rst_n(rst_n), .in_valid(1'b0), .in_ready(e_in_ready),
    .in_data(e_in_data), .in_lanes(4'hF), .ext_ena(e_ena),
    .out_valid(e_out_valid), .out_ready(1'b1), .out_data(e_out_data));

  // Zero-stage instance
  logic z_in_valid = 0, z_in_ready, z_out_valid, z_out_ready = 0;
  logic [DW-1:0] z_in_data = '0, z_out_data;
  logic [3:0] z_lanes = '0;
  logic [0:0] z_ena = '0;

  pipe_ena_top #(.NUM_STAGES(0)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(z_in_valid), .in_ready(z_in_ready),
    .in_data(z_in_data), .in_lanes(z_lanes), .ext_ena(z_ena),
    .out_valid(z_out_valid), .out_ready(z_out_ready), .out_data(z_out_data));

  function automatic logic [DW-1:0] add_each(input logic [DW-1:0] w, input int k);
    logic [DW-1:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = w[l*8 +: 8] + 8'(k);
    return r;
  endfunction

  function automatic logic [DW-1:0] boxed(input logic [DW-1:0] w, input logic [3:0] ln);
    logic [DW-1:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = ln[l] ? w[l*8 +: 8] : 8'hFF;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard
  logic [DW-1:0] exp_q[$];
  int n_acc = 0;

  task automatic hs_drive(input logic v, input logic [DW-1:0] d,
                          input logic [3:0] ln, input logic ordy);
    @(negedge clk);
    h_in_valid = v; h_in_data = d; h_lanes = ln; h_out_ready = ordy;
    #1;
    if (v && h_in_ready) begin
      exp_q.push_back(boxed(add_each(d, N), ln));
      n_acc++;
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && h_out_valid && h_out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected output", h_out_data, '0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(h_out_data == e, "R2/R5 ordered data", h_out_data, e);
      end
    end
  end

  // External step: pulse for one edge, then drop enables.
  task automatic ext_step(input logic [N-1:0] ena, input logic [DW-1:0] d);
    @(negedge clk);
    e_ena = ena; e_in_data = d;
    @(negedge clk);
    e_ena = '0;
    #1;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  localparam logic [DW-1:0] A = 32'h10203040;
  localparam logic [DW-1:0] B = 32'hA0B0C0FE;
  localparam logic [DW-1:0] C = 32'h01020304;

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    #1;
    chk(!h_out_valid, "R1 out_valid in reset", {31'd0, h_out_valid}, '0);
    chk(h_in_ready, "R1 in_ready in reset", {31'd0, h_in_ready}, 1);
    chk(h_out_data == '1, "R1 boxed idle output", h_out_data, '1);
    chk(e_out_data == '0, "R1 R8 raw output zero", e_out_data, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R5 random traffic under backpressure
    for (int i = 0; i < 400; i++) begin
      hs_drive(($urandom % 10) < 7, $urandom, 4'($urandom), ($urandom % 10) < 6);
    end
    for (int i = 0; i < 12; i++) hs_drive(1'b0, '0, '0, 1'b1);
    chk(exp_q.size() == 0, "R2 all words delivered", DW'(exp_q.size()), '0);
    chk(n_acc > 50, "R2 traffic volume", DW'(n_acc), 50);
    #1;
    chk(h_out_data == '1, "R5 idle output boxed", h_out_data, '1);

    // R3 latency into empty pipe
    hs_drive(1'b1, A, 4'hF, 1'b1);
    hs_drive(1'b0, '0, '0, 1'b1);
    hs_drive(1'b0, '0, '0, 1'b1);
    chk(!h_out_valid, "R3 not early", {31'd0, h_out_valid}, '0);
    hs_drive(1'b0, '0, '0, 1'b1);
    chk(h_out_valid, "R3 arrives on time", {31'd0, h_out_valid}, 1);
    chk(h_out_data == add_each(A, N), "R3 data", h_out_data, add_each(A, N));
    hs_drive(1'b0, '0, '0, 1'b1);

    // R4 fill with blocked output
    n_acc = 0;
    for (int i = 0; i < 6; i++) hs_drive(1'b1, add_each(C, i), 4'b0110, 1'b0);
    chk(n_acc == N, "R4 accepted count", DW'(n_acc), N);
    chk(!h_in_ready, "R4 full pipe not ready", {31'd0, h_in_ready}, '0);
    chk(h_out_data == boxed(add_each(C, N), 4'b0110), "R5 lane box while stalled",
        h_out_data, boxed(add_each(C, N), 4'b0110));
    for (int i = 0; i < 8; i++) hs_drive(1'b0, '0, '0, 1'b1);
    chk(exp_q.size() == 0, "R4 drained", DW'(exp_q.size()), '0);

    // R6/R7/R8 external enables, input valid low
    ext_step(3'b001, A);
    ext_step(3'b010, '0);
    ext_step(3'b001, B);
    ext_step(3'b100, '0);
    chk(e_out_data == add_each(A, 3), "R6 stage walk", e_out_data, add_each(A, 3));
    chk(!e_out_valid, "R6 valid stays low", {31'd0, e_out_valid}, '0);
    ext_step(3'b000, C);
    chk(e_out_data == add_each(A, 3), "R7 hold", e_out_data, add_each(A, 3));
    ext_step(3'b110, '0);
    chk(e_out_data == add_each(A, 3), "R6 two stages", e_out_data, add_each(A, 3));
    ext_step(3'b100, '0);
    chk(e_out_data == add_each(B, 3), "R6 second word", e_out_data, add_each(B, 3));
    ext_step(3'b011, C);
    ext_step(3'b100, '0);
    chk(e_out_data == add_each(B, 3), "R7 per-bit hold", e_out_data, add_each(B, 3));
    ext_step(3'b110, '0);
    ext_step(3'b100, '0);
    chk(e_out_data == add_each(C, 3), "R8 raw output unmasked", e_out_data, add_each(C, 3));
    chk(e_in_ready, "R6 ext instance empty", {31'd0, e_in_ready}, 1);

    // R9 zero stages
    @(negedge clk);
    z_in_valid = 1; z_in_data = B; z_lanes = 4'hF; z_out_ready = 0; #1;
    chk(z_out_valid && z_out_data == B, "R9 pass through", z_out_data, B);
    chk(!z_in_ready, "R9 ready follows", {31'd0, z_in_ready}, '0);
    z_out_ready = 1; z_lanes = 4'b0101; #1;
    chk(z_in_ready, "R9 ready follows high", {31'd0, z_in_ready}, 1);
    chk(z_out_data == boxed(B, 4'b0101), "R9 R5 lane mask", z_out_data, boxed(B, 4'b0101));
    z_ena = 1'b1; @(negedge clk); #1;
    chk(z_out_data == boxed(B, 4'b0101), "R9 enable ignored", z_out_data, boxed(B, 4'b0101));
    z_in_valid = 0; #1;
    chk(z_out_data == '1 && !z_out_valid, "R9 idle boxed", z_out_data, '1);

    finish_up();
  end

endmodule